// File: doc/BRIEF.md
# Bit-Error Receive Lock Monitor

This block watches a serial receive stream, one bit per strobe, and compares each bit against a reference bit produced by a local pattern generator that lives outside the block. A three-state lock machine (Search, Verify, Sync) decides whether the reference is aligned with the incoming data. While the machine is in Search, the block asks the external generator to seed itself from the received bits. Out-of-sync is reported whenever the machine is not in Sync.

While the machine is locked, every strobed bit is counted, and every mismatch is also counted as an error. Both counters saturate at all ones, and a single clear strobe zeroes them. Two sticky flags record events: any change of the out-of-sync status, and any counted bit error. Each flag is cleared by a write-one-to-clear pulse. Each flag is also masked by an enable bit and drives a single interrupt line.

Top module: `bert_rx_monitor`

## Requirements
- R1: After reset: `oos`=1, `ref_load`=1, both counters are 0, `flags`=0 and `irq`=0.
- R2: In Search, `ref_load` is 1 and `oos` is 1. After SEED_LEN strobed bits, the machine enters Verify. Mismatches in Search are ignored. `ref_load` is 0 outside Search.
- R3: In Verify, VERIFY_LEN consecutive matching strobed bits move the machine to Sync, and `oos` drops to 0. A single mismatch in Verify returns it to Search.
- R4: In Sync, a single mismatching strobed bit moves the machine to Verify, and `oos` becomes 1 one cycle later.
- R5: A `resync` pulse puts the machine in Search on the next cycle from any state. This sets `oos`=1 and `ref_load`=1.
- R6: A strobed bit that arrives while `oos`=0 adds 1 to `bit_count`. If it mismatches, it also adds 1 to `err_count`. While `oos`=1, neither counter changes.
- R7: Each counter holds at all ones instead of wrapping.
- R8: `cnt_clear` sets both counters to 0 on the next cycle. It takes precedence over a simultaneous increment.
- R9: `flags[0]` is set on the same clock edge at which `oos` changes, in either direction.
- R10: `flags[1]` is set on the same edge as a counted mismatch, that is, a mismatch while `oos`=0.
- R11: A 1 in bit i of `flag_clr` clears `flags[i]` on the next edge. A set event in the same cycle wins over the clear.
- R12: `irq` is 1 exactly when some `flags[i]` and `irq_en[i]` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe: `rx_bit` and `ref_bit` are valid this cycle |
| rx_bit | input | 1 | Received data bit |
| ref_bit | input | 1 | Reference bit from the external pattern generator |
| resync | input | 1 | Force the lock machine back to Search |
| cnt_clear | input | 1 | Zero both counters |
| flag_clr | input | 2 | Write-one-to-clear pulse per flag (bit 0 out-of-sync change, bit 1 bit error) |
| irq_en | input | 2 | Interrupt enable per flag |
| oos | output | 1 | Out-of-sync status |
| ref_load | output | 1 | Request to the generator to seed from received data |
| flags | output | 2 | Sticky flags: bit 0 out-of-sync change, bit 1 bit error |
| irq | output | 1 | Interrupt |
| bit_count | output | CNT_W | Saturating count of bits received while locked |
| err_count | output | CNT_W | Saturating count of errors received while locked |

## Verification
The lock machine is driven with several stimulus patterns, each of which separates one transition from the others:
- Long runs of matching bits show that seeding and verification take exact lengths.
- A mismatch placed just before the final verify bit would show whether a single error is enough to drop the machine.
- A lone error while locked separates the Sync-to-Verify step from a full loss of lock.
- A second error right after the first separates the Verify-to-Search step.
- Runs of matching bits while out of sync show whether counting is gated.

The corner cases each try one precedence rule or boundary:
- A flag clear arriving on the same edge as the lock event that sets the flag.
- A counter clear arriving together with an increment.
- A run of bits long enough to reach the counter's maximum value.

// File: rtl/bert_mon_pkg.sv
package bert_mon_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_SYNC   = 2'd2
  } lock_st_e;

  localparam int FLAG_OOS = 0;
  localparam int FLAG_ERR = 1;
  localparam int N_FLAGS  = 2;
endpackage

// File: rtl/bert_sync_fsm.sv
module bert_sync_fsm
  import bert_mon_pkg::*;
#(
  parameter int SEED_LEN   = 32,
  parameter int VERIFY_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic mismatch,
  input  logic resync,
  output logic oos,
  output logic oos_toggle,
  output logic ref_load
);
  localparam int MAX_LEN = (SEED_LEN > VERIFY_LEN) ? SEED_LEN : VERIFY_LEN;
  localparam int RUN_W   = $clog2(MAX_LEN + 1);
  localparam logic [RUN_W-1:0] SEED_LAST   = RUN_W'(SEED_LEN - 1);
  localparam logic [RUN_W-1:0] VERIFY_LAST = RUN_W'(VERIFY_LEN - 1);

  lock_st_e         st_q, st_n;
  logic [RUN_W-1:0] run_q, run_n;

  always_comb begin
    st_n  = st_q;
    run_n = run_q;
    if (resync) begin
      st_n  = ST_SEARCH;
      run_n = '0;
    end else if (bit_valid) begin
      case (st_q)
        ST_SEARCH: begin
          if (run_q == SEED_LAST) begin
            st_n  = ST_VERIFY;
            run_n = '0;
          end else begin
            run_n = run_q + 1'b1;
          end
        end
        ST_VERIFY: begin
          if (mismatch) begin
            st_n  = ST_SEARCH;
            run_n = '0;
          end else if (run_q == VERIFY_LAST) begin
            st_n  = ST_SYNC;
            run_n = '0;
          end else begin
            run_n = run_q + 1'b1;
          end
        end
        ST_SYNC: begin
          if (mismatch) begin
            st_n  = ST_VERIFY;
            run_n = '0;
          end
        end
        default: begin
          st_n  = ST_SEARCH;
          run_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SEARCH;
      run_q <= '0;
    end else begin
      st_q  <= st_n;
      run_q <= run_n;
    end
  end

  assign oos        = (st_q != ST_SYNC);
  assign oos_toggle = (st_q == ST_SYNC) != (st_n == ST_SYNC);
  assign ref_load   = (st_q == ST_SEARCH);

  p_verify_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VERIFY && bit_valid && mismatch && !resync) |=> (st_q == ST_SEARCH));
  p_sync_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC && bit_valid && mismatch && !resync) |=> (st_q == ST_VERIFY));
  p_resync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (oos && ref_load));
  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oos_toggle |=> (oos != $past(oos)));
endmodule

// File: rtl/bert_sat_counter.sv
module bert_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && (cnt_q != TOP));
    cnt_n  = clr ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign count = cnt_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count));
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !clr) |=> (count == TOP));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/bert_flag_bank.sv
module bert_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flag_q, flag_n;

  always_comb begin
    flag_n = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_n;
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & en);

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
    p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flags[i]);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]);
  end
endmodule

// File: rtl/bert_rx_monitor.sv
module bert_rx_monitor
  import bert_mon_pkg::*;
#(
  parameter int SEED_LEN   = 32,
  parameter int VERIFY_LEN = 32,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             rx_bit,
  input  logic             ref_bit,
  input  logic             resync,
  input  logic             cnt_clear,
  input  logic [1:0]       flag_clr,
  input  logic [1:0]       irq_en,
  output logic             oos,
  output logic             ref_load,
  output logic [1:0]       flags,
  output logic             irq,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count
);
  logic               mismatch;
  logic               oos_toggle;
  logic               count_bit;
  logic               count_err;
  logic [N_FLAGS-1:0] flag_set;

  assign mismatch  = rx_bit ^ ref_bit;
  assign count_bit = bit_valid && !oos;
  assign count_err = count_bit && mismatch;

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_OOS] = oos_toggle;
    flag_set[FLAG_ERR] = count_err;
  end

  bert_sync_fsm #(
    .SEED_LEN  (SEED_LEN),
    .VERIFY_LEN(VERIFY_LEN)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .mismatch  (mismatch),
    .resync    (resync),
    .oos       (oos),
    .oos_toggle(oos_toggle),
    .ref_load  (ref_load)
  );

  bert_sat_counter #(.W(CNT_W)) u_bits (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clear),
    .inc  (count_bit),
    .count(bit_count)
  );

  bert_sat_counter #(.W(CNT_W)) u_errs (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clear),
    .inc  (count_err),
    .count(err_count)
  );

  bert_flag_bank #(.N(N_FLAGS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (flag_set),
    .clr  (flag_clr),
    .en   (irq_en),
    .flags(flags),
    .irq  (irq)
  );

  p_no_count_oos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oos && !cnt_clear) |=> ($stable(bit_count) && $stable(err_count)));
  p_err_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !oos && mismatch) |=> flags[FLAG_ERR]);
endmodule

// File: tb/sim_bert_rx_monitor.sv
module sim_bert_rx_monitor;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, rx_bit = 1'b0, ref_bit = 1'b0;
  logic resync = 1'b0, cnt_clear = 1'b0;
  logic [1:0] flag_clr = 2'b00, irq_en = 2'b00;
  logic oos, ref_load, irq;
  logic [1:0] flags;
  logic [CW-1:0] bit_count, err_count;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] pat = 16'hACE1;
  int exp_bits = 0;
  int exp_errs = 0;

  always #5 clk = ~clk;

  bert_rx_monitor #(.SEED_LEN(32), .VERIFY_LEN(32), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .ref_bit(ref_bit), .resync(resync), .cnt_clear(cnt_clear),
    .flag_clr(flag_clr), .irq_en(irq_en), .oos(oos), .ref_load(ref_load),
    .flags(flags), .irq(irq), .bit_count(bit_count), .err_count(err_count)
  );

  // Segment: count[27:16] err_first[15] exp_oos[14] bit_delta[13:7] err_delta[6:0]
  localparam int NSEG = 10;
  localparam logic [27:0] SEG [NSEG] = '{
    {12'd32, 1'b0, 1'b1, 7'd0,  7'd0},  // R2 seeding
    {12'd31, 1'b0, 1'b1, 7'd0,  7'd0},  // R3 one short of lock
    {12'd1,  1'b0, 1'b0, 7'd0,  7'd0},  // R3 lock
    {12'd20, 1'b0, 1'b0, 7'd20, 7'd0},  // R6 matches counted
    {12'd1,  1'b1, 1'b1, 7'd1,  7'd1},  // R4 error in sync
    {12'd32, 1'b0, 1'b0, 7'd0,  7'd0},  // R3 relock, nothing counted
    {12'd5,  1'b0, 1'b0, 7'd5,  7'd0},
    {12'd1,  1'b1, 1'b1, 7'd1,  7'd1},  // R4
    {12'd1,  1'b1, 1'b1, 7'd0,  7'd0},  // R3 error in verify -> search
    {12'd10, 1'b0, 1'b1, 7'd0,  7'd0}   // R2 search, not counted
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic mis);
    pat       = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
    ref_bit   = pat[0];
    rx_bit    = pat[0] ^ mis;
    bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic run_matches(input int n);
    for (int k = 0; k < n; k++) drive_bit(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oos", 32'(oos), 1);
    check("R1 ref_load", 32'(ref_load), 1);
    check("R1 bit_count", 32'(bit_count), 0);
    check("R1 err_count", 32'(err_count), 0);
    check("R1 flags", 32'(flags), 0);
    check("R1 irq", 32'(irq), 0);

    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEG[s][27:16]); k++)
        drive_bit(SEG[s][15] && (k == 0));
      exp_bits += int'(SEG[s][13:7]);
      exp_errs += int'(SEG[s][6:0]);
      check("R2/R3/R4 oos per segment", 32'(oos), 32'(SEG[s][14]));
      check("R6 bit_count per segment", 32'(bit_count), 32'(exp_bits));
      check("R6 err_count per segment", 32'(err_count), 32'(exp_errs));
    end
    check("R2 ref_load in search", 32'(ref_load), 1);
    check("R9 oos change flag", 32'(flags[0]), 1);
    check("R10 error flag", 32'(flags[1]), 1);
    check("R12 irq masked", 32'(irq), 0);
    irq_en = 2'b10;
    #1 check("R12 irq enabled", 32'(irq), 1);

    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
    check("R11 w1c clears", 32'(flags), 0);
    check("R12 irq after clear", 32'(irq), 0);

    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    check("R8 clear bits", 32'(bit_count), 0);
    check("R8 clear errs", 32'(err_count), 0);

    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    check("R5 resync oos", 32'(oos), 1);
    check("R5 resync ref_load", 32'(ref_load), 1);
    check("R9 no flag without change", 32'(flags[0]), 0);

    // Mismatches are irrelevant while seeding
    for (int k = 0; k < 32; k++) drive_bit(k[0]);
    check("R2 ref_load off in verify", 32'(ref_load), 0);
    run_matches(31);
    check("R3 still verifying", 32'(oos), 1);
    flag_clr = 2'b01;
    drive_bit(1'b0);
    flag_clr = 2'b00;
    check("R3 locked", 32'(oos), 0);
    check("R11 set beats clear", 32'(flags[0]), 1);
    check("R2 ref_load off in sync", 32'(ref_load), 0);

    run_matches(1030);
    check("R7 bit_count saturates", 32'(bit_count), 32'((1 << CW) - 1));
    check("R7 err_count untouched", 32'(err_count), 0);

    cnt_clear = 1'b1;
    drive_bit(1'b1);
    cnt_clear = 1'b0;
    check("R8 clear beats increment", 32'(bit_count), 0);
    check("R8 clear beats error", 32'(err_count), 0);
    check("R4 error drops lock", 32'(oos), 1);

    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
    run_matches(32);
    check("R9 flag on regaining lock", 32'(flags[0]), 1);
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    check("R5 resync from sync", 32'(oos), 1);
    check("R9 flag on losing lock", 32'(flags[0]), 1);
    irq_en = 2'b01;
    #1 check("R12 irq from oos flag", 32'(irq), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule